// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches an SMBus interface and raises a sticky timeout flag when the bus misbehaves for too long. It measures time against its functional clock using already-synchronised SCL and SDA levels, START/STOP detect strobes from the protocol engine, and an indication that this device is currently stretching the clock.

A primary check uses a 12-bit reload value and a mode bit. In low mode it flags SCL held low for too long, with a step of 2048 clocks. In idle mode it flags both lines held high, with a step of 4 clocks, which serves as bus-idle detection. A separate cumulative check uses its own 12-bit reload value. It adds up the cycles during which this device stretches the clock across one transfer and flags when the total grows too large. Each check has its own enable. The reload values and the mode cannot be rewritten while the matching enable is set.

The flag stays set until a one-cycle clear pulse removes it. If a new timeout occurs in the same cycle as the clear, the flag stays set.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After synchronous active-low reset, the flag is 0, both enables are 0, both reload values are 0 and the primary mode is low mode (0).
- R2: In low mode (`cfgIdleMode`=0) with the primary check enabled, the flag rises at the clock edge where SCL has been sampled low on (A+1)×2048 consecutive edges, where A is the primary reload value. An edge that samples SCL high restarts the measurement.
- R3: In idle mode (`cfgIdleMode`=1) with the primary check enabled, the flag rises at the edge where SCL and SDA have both been sampled high on (A+1)×4 consecutive edges. Either line sampled low restarts the measurement.
- R4: While the primary enable is 0, the primary check does not count and cannot set the flag.
- R5: A write to the primary reload value and mode (`cfgWrA`) is ignored while the primary enable is 1.
- R6: With the cumulative check enabled, edges that sample `ownStretch`=1 accumulate and pause (without resetting) while it is 0. The flag rises at the edge that completes (B+1)×2048 stretch cycles, where B is the cumulative reload value.
- R7: A START or STOP strobe, or a cumulative enable of 0, resets the accumulated stretch count to zero.
- R8: A write to the cumulative reload value (`cfgWrB`) is ignored while the cumulative enable is 1.
- R9: The flag stays set until `flagClr` is sampled high, and it reads 0 after that edge.
- R10: If a timeout completes on the same edge that samples `flagClr`=1, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Synchronous active-low reset |
| sclLevel | input | 1 | Synchronised SCL level |
| sdaLevel | input | 1 | Synchronised SDA level |
| startDet | input | 1 | One-cycle START detected strobe |
| stopDet | input | 1 | One-cycle STOP detected strobe |
| ownStretch | input | 1 | This device is holding SCL low |
| cfgWrA | input | 1 | Write strobe for the primary reload value and mode |
| cfgReloadA | input | 12 | Primary reload value to write |
| cfgIdleMode | input | 1 | Mode to write: 0 low mode, 1 idle mode |
| cfgWrB | input | 1 | Write strobe for the cumulative reload value |
| cfgReloadB | input | 12 | Cumulative reload value to write |
| ctlWr | input | 1 | Write strobe for both enables |
| enPrimaryIn | input | 1 | Primary enable value to write |
| enCumulIn | input | 1 | Cumulative enable value to write |
| flagClr | input | 1 | One-cycle flag clear |
| timeoutFlag | output | 1 | Sticky timeout flag |

## Verification
Enables and configuration written on one edge start to govern counting from the following edge. The flag turns 1 on exactly the edge that samples the last qualifying cycle, and a clear takes effect on the edge that samples it. The bench changes inputs on falling edges and counts rising edges from the first qualifying sample. It reads the flag on the falling edge after the final counted edge, one edge short of the limit (expecting 0) and at the limit (expecting 1), so an off-by-one error in either direction shows up.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;
  localparam int RELOAD_W = 12;

  typedef struct packed {
    logic runA;
    logic clrA;
    logic idleSel;
    logic runB;
    logic clrB;
  } tmoStrobes_t;
endpackage

// File: rtl/smbus_tmo_cnt.sv
module smbus_tmo_cnt #(
  parameter int DIV_LONG  = 2048,
  parameter int DIV_SHORT = 4,
  parameter int RELOAD_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                run,
  input  logic                clr,
  input  logic                shortSel,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expire,
  output logic [RELOAD_W-1:0] unitCnt
);
  localparam int PRE_W = (DIV_LONG > 1) ? $clog2(DIV_LONG) : 1;
  localparam logic [PRE_W-1:0] LAST_LONG  = PRE_W'(DIV_LONG - 1);
  localparam logic [PRE_W-1:0] LAST_SHORT = PRE_W'(DIV_SHORT - 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic             wrap;

  always_comb begin
    preLast = shortSel ? LAST_SHORT : LAST_LONG;
    wrap    = run && !clr && (preCnt == preLast);
    expire  = wrap && (unitCnt == reload);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (run) begin
      if (wrap) begin
        preCnt  <= '0;
        unitCnt <= expire ? '0 : unitCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smbus_tmo_datapath.sv
module smbus_tmo_datapath
  import smbus_tmo_pkg::*;
#(
  parameter int LOW_DIV  = 2048,
  parameter int IDLE_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmoStrobes_t         strobes,
  input  logic [RELOAD_W-1:0] reloadA,
  input  logic [RELOAD_W-1:0] reloadB,
  output logic                expA,
  output logic                expB,
  output logic [RELOAD_W-1:0] unitA,
  output logic [RELOAD_W-1:0] unitB
);
  smbus_tmo_cnt #(
    .DIV_LONG (LOW_DIV),
    .DIV_SHORT(IDLE_DIV),
    .RELOAD_W (RELOAD_W)
  ) u_cntPrimary (
    .clk     (clk),
    .rstN    (rstN),
    .run     (strobes.runA),
    .clr     (strobes.clrA),
    .shortSel(strobes.idleSel),
    .reload  (reloadA),
    .expire  (expA),
    .unitCnt (unitA)
  );

  smbus_tmo_cnt #(
    .DIV_LONG (LOW_DIV),
    .DIV_SHORT(LOW_DIV),
    .RELOAD_W (RELOAD_W)
  ) u_cntCumul (
    .clk     (clk),
    .rstN    (rstN),
    .run     (strobes.runB),
    .clr     (strobes.clrB),
    .shortSel(1'b0),
    .reload  (reloadB),
    .expire  (expB),
    .unitCnt (unitB)
  );
endmodule

// File: rtl/smbus_tmo_ctrl.sv
module smbus_tmo_ctrl
  import smbus_tmo_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclLevel,
  input  logic                sdaLevel,
  input  logic                startDet,
  input  logic                stopDet,
  input  logic                ownStretch,
  input  logic                cfgWrA,
  input  logic [RELOAD_W-1:0] cfgReloadA,
  input  logic                cfgIdleMode,
  input  logic                cfgWrB,
  input  logic [RELOAD_W-1:0] cfgReloadB,
  input  logic                ctlWr,
  input  logic                enPrimaryIn,
  input  logic                enCumulIn,
  input  logic                flagClr,
  input  logic                expA,
  input  logic                expB,
  output tmoStrobes_t         strobes,
  output logic [RELOAD_W-1:0] reloadA,
  output logic [RELOAD_W-1:0] reloadB,
  output logic                idleMode,
  output logic                enPrimary,
  output logic                enCumul,
  output logic                timeoutFlag
);
  logic condA;
  logic xferEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadA   <= '0;
      reloadB   <= '0;
      idleMode  <= 1'b0;
      enPrimary <= 1'b0;
      enCumul   <= 1'b0;
    end else begin
      if (cfgWrA && !enPrimary) begin
        reloadA  <= cfgReloadA;
        idleMode <= cfgIdleMode;
      end
      if (cfgWrB && !enCumul) begin
        reloadB <= cfgReloadB;
      end
      if (ctlWr) begin
        enPrimary <= enPrimaryIn;
        enCumul   <= enCumulIn;
      end
    end
  end

  always_comb begin
    condA    = idleMode ? (sclLevel && sdaLevel) : !sclLevel;
    xferEdge = startDet || stopDet;
    strobes.runA    = enPrimary && condA;
    strobes.clrA    = !(enPrimary && condA);
    strobes.idleSel = idleMode;
    strobes.runB    = enCumul && ownStretch && !xferEdge;
    strobes.clrB    = !enCumul || xferEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
    end else if (expA || expB) begin
      timeoutFlag <= 1'b1;
    end else if (flagClr) begin
      timeoutFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon
  import smbus_tmo_pkg::*;
#(
  parameter int LOW_DIV  = 2048,
  parameter int IDLE_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclLevel,
  input  logic                sdaLevel,
  input  logic                startDet,
  input  logic                stopDet,
  input  logic                ownStretch,
  input  logic                cfgWrA,
  input  logic [RELOAD_W-1:0] cfgReloadA,
  input  logic                cfgIdleMode,
  input  logic                cfgWrB,
  input  logic [RELOAD_W-1:0] cfgReloadB,
  input  logic                ctlWr,
  input  logic                enPrimaryIn,
  input  logic                enCumulIn,
  input  logic                flagClr,
  output logic                timeoutFlag
);
  tmoStrobes_t         strobes;
  logic [RELOAD_W-1:0] reloadA;
  logic [RELOAD_W-1:0] reloadB;
  logic [RELOAD_W-1:0] unitA;
  logic [RELOAD_W-1:0] unitB;
  logic                idleMode;
  logic                enPrimary;
  logic                enCumul;
  logic                expA;
  logic                expB;

  smbus_tmo_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclLevel   (sclLevel),
    .sdaLevel   (sdaLevel),
    .startDet   (startDet),
    .stopDet    (stopDet),
    .ownStretch (ownStretch),
    .cfgWrA     (cfgWrA),
    .cfgReloadA (cfgReloadA),
    .cfgIdleMode(cfgIdleMode),
    .cfgWrB     (cfgWrB),
    .cfgReloadB (cfgReloadB),
    .ctlWr      (ctlWr),
    .enPrimaryIn(enPrimaryIn),
    .enCumulIn  (enCumulIn),
    .flagClr    (flagClr),
    .expA       (expA),
    .expB       (expB),
    .strobes    (strobes),
    .reloadA    (reloadA),
    .reloadB    (reloadB),
    .idleMode   (idleMode),
    .enPrimary  (enPrimary),
    .enCumul    (enCumul),
    .timeoutFlag(timeoutFlag)
  );

  smbus_tmo_datapath #(
    .LOW_DIV (LOW_DIV),
    .IDLE_DIV(IDLE_DIV)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .reloadA(reloadA),
    .reloadB(reloadB),
    .expA   (expA),
    .expB   (expB),
    .unitA  (unitA),
    .unitB  (unitB)
  );
endmodule

// File: rtl/smbus_timeout_chk.sv
module smbus_timeout_chk #(
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          flag,
  input logic          flagClr,
  input logic          expA,
  input logic          expB,
  input logic          enPrimary,
  input logic          enCumul,
  input logic          cfgWrA,
  input logic          cfgWrB,
  input logic          ownStretch,
  input logic          startDet,
  input logic          stopDet,
  input logic [RW-1:0] reloadA,
  input logic [RW-1:0] reloadB,
  input logic          idleMode,
  input logic [RW-1:0] unitA,
  input logic [RW-1:0] unitB
);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    flag && !flagClr |=> flag);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagClr && !expA && !expB |=> !flag);

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (expA || expB) |=> flag);

  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(expA || expB));

  p_primary_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !enPrimary |=> (unitA == '0) && !expA);

  p_lock_a_r5: assert property (@(posedge clk) disable iff (!rstN)
    enPrimary && cfgWrA |=> $stable(reloadA) && $stable(idleMode));

  p_pause_r6: assert property (@(posedge clk) disable iff (!rstN)
    enCumul && !ownStretch && !startDet && !stopDet |=> $stable(unitB));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startDet || stopDet || !enCumul) |=> unitB == '0);

  p_lock_b_r8: assert property (@(posedge clk) disable iff (!rstN)
    enCumul && cfgWrB |=> $stable(reloadB));
endmodule

bind smbus_timeout_mon smbus_timeout_chk #(.RW(12)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .flag      (timeoutFlag),
  .flagClr   (flagClr),
  .expA      (expA),
  .expB      (expB),
  .enPrimary (enPrimary),
  .enCumul   (enCumul),
  .cfgWrA    (cfgWrA),
  .cfgWrB    (cfgWrB),
  .ownStretch(ownStretch),
  .startDet  (startDet),
  .stopDet   (stopDet),
  .reloadA   (reloadA),
  .reloadB   (reloadB),
  .idleMode  (idleMode),
  .unitA     (unitA),
  .unitB     (unitB)
);

// File: tb/smbus_timeout_mon_tb.sv
module smbus_timeout_mon_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLevel = 1'b1, sdaLevel = 1'b0;
  logic startDet = 1'b0, stopDet = 1'b0, ownStretch = 1'b0;
  logic cfgWrA = 1'b0, cfgIdleMode = 1'b0, cfgWrB = 1'b0;
  logic [11:0] cfgReloadA = '0, cfgReloadB = '0;
  logic ctlWr = 1'b0, enPrimaryIn = 1'b0, enCumulIn = 1'b0;
  logic flagClr = 1'b0;
  logic timeoutFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  smbus_timeout_mon u_dut (
    .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaLevel(sdaLevel),
    .startDet(startDet), .stopDet(stopDet), .ownStretch(ownStretch),
    .cfgWrA(cfgWrA), .cfgReloadA(cfgReloadA), .cfgIdleMode(cfgIdleMode),
    .cfgWrB(cfgWrB), .cfgReloadB(cfgReloadB), .ctlWr(ctlWr),
    .enPrimaryIn(enPrimaryIn), .enCumulIn(enCumulIn), .flagClr(flagClr),
    .timeoutFlag(timeoutFlag)
  );

  // vector: {mode, reload[11:0], hold cycles[15:0], expected flag}
  localparam logic [29:0] VEC [0:7] = '{
    {1'b0, 12'd0, 16'd2047, 1'b0},
    {1'b0, 12'd0, 16'd2048, 1'b1},
    {1'b1, 12'd0, 16'd3,    1'b0},
    {1'b1, 12'd0, 16'd4,    1'b1},
    {1'b1, 12'd5, 16'd23,   1'b0},
    {1'b1, 12'd5, 16'd24,   1'b1},
    {1'b0, 12'd1, 16'd4095, 1'b0},
    {1'b0, 12'd1, 16'd4096, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: timeoutFlag=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic neutral();
    sclLevel = 1'b1; sdaLevel = 1'b0; ownStretch = 1'b0;
    startDet = 1'b0; stopDet = 1'b0;
  endtask

  task automatic setupPrimary(input logic mode, input logic [11:0] rel);
    neutral();
    ctlWr = 1'b1; enPrimaryIn = 1'b0; enCumulIn = 1'b0; flagClr = 1'b1;
    tick(1);
    ctlWr = 1'b0; flagClr = 1'b0;
    cfgWrA = 1'b1; cfgIdleMode = mode; cfgReloadA = rel;
    tick(1);
    cfgWrA = 1'b0; ctlWr = 1'b1; enPrimaryIn = 1'b1;
    tick(1);
    ctlWr = 1'b0;
  endtask

  task automatic setupCumul(input logic [11:0] rel);
    neutral();
    ctlWr = 1'b1; enPrimaryIn = 1'b0; enCumulIn = 1'b0; flagClr = 1'b1;
    tick(1);
    ctlWr = 1'b0; flagClr = 1'b0;
    cfgWrB = 1'b1; cfgReloadB = rel;
    tick(1);
    cfgWrB = 1'b0; ctlWr = 1'b1; enCumulIn = 1'b1;
    tick(1);
    ctlWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [29:0] v;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1: reset state
    chk("R1 reset flag", timeoutFlag, 1'b0);

    // R4 and R1: enables reset to 0, SCL low long
    sclLevel = 1'b0;
    tick(2100);
    chk("R4 disabled primary", timeoutFlag, 1'b0);
    neutral();

    // R1: cumulative reload resets to 0, enable without writing reload
    ctlWr = 1'b1; enCumulIn = 1'b1;
    tick(1);
    ctlWr = 1'b0; ownStretch = 1'b1;
    tick(2047);
    chk("R1 reloadB reset", timeoutFlag, 1'b0);
    tick(1);
    chk("R1 reloadB reset", timeoutFlag, 1'b1);

    // R2 / R3 vector table
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      setupPrimary(v[29], v[28:17]);
      if (v[29]) sdaLevel = 1'b1; else sclLevel = 1'b0;
      tick(int'(v[16:1]));
      chk(v[29] ? "R3 idle vector" : "R2 low vector", timeoutFlag, v[0]);
    end

    // R2 restart on SCL high
    setupPrimary(1'b0, 12'd0);
    sclLevel = 1'b0; tick(2000);
    sclLevel = 1'b1; tick(1);
    sclLevel = 1'b0; tick(2047);
    chk("R2 restart", timeoutFlag, 1'b0);
    tick(1);
    chk("R2 restart", timeoutFlag, 1'b1);

    // R3 restart on SDA low
    setupPrimary(1'b1, 12'd0);
    sdaLevel = 1'b1; tick(3);
    sdaLevel = 1'b0; tick(1);
    sdaLevel = 1'b1; tick(3);
    chk("R3 restart", timeoutFlag, 1'b0);
    tick(1);
    chk("R3 restart", timeoutFlag, 1'b1);

    // R5: config write ignored while enabled
    setupPrimary(1'b0, 12'd0);
    cfgWrA = 1'b1; cfgIdleMode = 1'b1; cfgReloadA = 12'd5;
    tick(1);
    cfgWrA = 1'b0;
    sclLevel = 1'b0; tick(2047);
    chk("R5 locked config", timeoutFlag, 1'b0);
    tick(1);
    chk("R5 locked config", timeoutFlag, 1'b1);

    // R9: sticky, then clear
    sclLevel = 1'b1;
    tick(10);
    chk("R9 sticky", timeoutFlag, 1'b1);
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
    chk("R9 cleared", timeoutFlag, 1'b0);

    // R6: accumulate with pause
    setupCumul(12'd0);
    ownStretch = 1'b1; tick(1000);
    ownStretch = 1'b0; tick(500);
    ownStretch = 1'b1; tick(1047);
    chk("R6 pause", timeoutFlag, 1'b0);
    tick(1);
    chk("R6 accumulate", timeoutFlag, 1'b1);

    // R7: START restarts
    setupCumul(12'd0);
    ownStretch = 1'b1; tick(1500);
    ownStretch = 1'b0; startDet = 1'b1; tick(1);
    startDet = 1'b0; ownStretch = 1'b1; tick(2047);
    chk("R7 start restart", timeoutFlag, 1'b0);
    tick(1);
    chk("R7 start restart", timeoutFlag, 1'b1);

    // R7: STOP restarts
    setupCumul(12'd0);
    ownStretch = 1'b1; tick(1500);
    ownStretch = 1'b0; stopDet = 1'b1; tick(1);
    stopDet = 1'b0; ownStretch = 1'b1; tick(2047);
    chk("R7 stop restart", timeoutFlag, 1'b0);

    // R7: enable cleared restarts
    setupCumul(12'd0);
    ownStretch = 1'b1; tick(1500);
    ownStretch = 1'b0; ctlWr = 1'b1; enCumulIn = 1'b0; tick(1);
    enCumulIn = 1'b1; tick(1);
    ctlWr = 1'b0; ownStretch = 1'b1; tick(2047);
    chk("R7 disable restart", timeoutFlag, 1'b0);
    tick(1);
    chk("R7 disable restart", timeoutFlag, 1'b1);

    // R8: reloadB write ignored while enabled
    setupCumul(12'd0);
    cfgWrB = 1'b1; cfgReloadB = 12'd1; tick(1);
    cfgWrB = 1'b0;
    ownStretch = 1'b1; tick(2048);
    chk("R8 locked reloadB", timeoutFlag, 1'b1);

    // R10: clear coincides with new event
    setupCumul(12'd0);
    ownStretch = 1'b1; tick(2048);
    chk("R10 first event", timeoutFlag, 1'b1);
    tick(2047);
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
    chk("R10 event beats clear", timeoutFlag, 1'b1);
    ownStretch = 1'b0;
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
    chk("R10 later clear", timeoutFlag, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule